// File: doc/BRIEF.md
# Staged Palette Lookup-Table Writer

This block is the host-side front end of a colour palette. The palette holds 256 entries of 18 bits each, with 6 bits for each of red, green and blue. A host programs it over a byte-wide register bus.

The host first loads each colour component into its own write-only holding register. It then writes the entry index to a commit register. That single write copies all three held components into the addressed entry at once, so no entry ever shows a colour that is only partly updated. The holding registers keep their values after a commit, so the same colour can be copied to further entries by writing only new indices.

The display pipeline uses a separate read port. It presents an 8-bit pixel index and receives the 18-bit colour one clock later.

Top module: `palette_stage_writer`

## Requirements
- R1: A write to offset 08h loads data bits 7..2 into the blue holding register. Data bits 1..0 are discarded.
- R2: A write to offset 09h loads data bits 7..2 into the green holding register.
- R3: A write to offset 0Ah loads data bits 7..2 into the red holding register.
- R4: A write to any holding register leaves every table entry unchanged.
- R5: A write to offset 0Bh stores {red, green, blue} into the entry whose index is the written byte. Red occupies bits 17..12 of the entry, green bits 11..6 and blue bits 5..0.
- R6: Holding registers keep their values after a commit. A second commit to another index stores the same colour there.
- R7: The colour output presents the entry selected by the pixel index sampled at the previous rising clock edge.
- R8: When a commit and a pixel read address the same index in the same cycle, the output shows the newly committed colour.
- R9: Reset clears all three holding registers to zero. The table contents are not reset.
- R10: The register read-data output is always zero, because every register is write-only.
- R11: Writes to offsets other than 08h..0Bh change neither the holding registers nor the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, active high |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, always zero |
| pix_idx | input | 8 | Pixel-side palette index |
| pix_color | output | 18 | Colour of the entry, {red, green, blue} |

## Verification
Directed sequences come first. They commit straight after reset, which distinguishes cleared holding registers from stale ones. They also reread an entry after component-only writes, which exposes any table write made before a commit. Repeated commits without new component writes separate retained holding values from registers that clear on commit. Random traffic then mixes component writes, commits, writes to unused offsets and pixel reads. The pixel index is often steered onto the index being committed, so that write-first behaviour is told apart from read-first behaviour and a wrong field order in the entry shows up as a colour mismatch.

// File: rtl/pal_pkg.sv
package pal_pkg;
   // Component slots inside a palette entry, lowest bits first
   typedef enum logic [1:0] {
      SLOT_BLUE  = 2'd0,
      SLOT_GREEN = 2'd1,
      SLOT_RED   = 2'd2
   } pal_slot_e;

   localparam int unsigned NUM_SLOTS = 3;
endpackage

// File: rtl/pal_stage_regs.sv
module pal_stage_regs
   import pal_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned COMP_W   = 6,
   parameter int unsigned IDX_W    = 8,
   parameter logic [7:0]  OFS_BASE = 8'h08
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr,
   input  logic [7:0]                      addr,
   input  logic [DATA_W-1:0]               wdata,
   output logic [NUM_SLOTS*COMP_W-1:0]     held,
   output logic                            commit,
   output logic [IDX_W-1:0]                commit_idx,
   output logic [DATA_W-1:0]               rdata
);
   localparam int unsigned COMP_LSB   = DATA_W - COMP_W;
   localparam logic [7:0]  OFS_COMMIT = OFS_BASE + 8'(NUM_SLOTS);

   if (COMP_W > DATA_W) begin : g_bad_comp
      $error("COMP_W must not exceed DATA_W");
   end
   if (IDX_W > DATA_W) begin : g_bad_idx
      $error("IDX_W must not exceed DATA_W");
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam logic [7:0] SLOT_OFS = OFS_BASE + 8'(s);
      logic [COMP_W-1:0] hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
         end else if (wr && (addr == SLOT_OFS)) begin
            hold_q <= wdata[DATA_W-1:COMP_LSB];
         end
      end

      assign held[s*COMP_W +: COMP_W] = hold_q;
   end

   assign commit     = wr && (addr == OFS_COMMIT);
   assign commit_idx = wdata[IDX_W-1:0];
   assign rdata      = '0;
endmodule

// File: rtl/pal_lut_ram.sv
module pal_lut_ram #(
   parameter int unsigned IDX_W       = 8,
   parameter int unsigned ENTRY_W     = 18,
   parameter bit          WRITE_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               we,
   input  logic [IDX_W-1:0]   widx,
   input  logic [ENTRY_W-1:0] wdata,
   input  logic [IDX_W-1:0]   ridx,
   output logic [ENTRY_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   if (IDX_W > 12) begin : g_bad_depth
      $error("IDX_W too large for a register-built table");
   end

   logic [ENTRY_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[widx] <= wdata;
      end
   end

   if (WRITE_FIRST) begin : g_wfirst
      always_ff @(posedge clk) begin
         if (we && (widx == ridx)) begin
            rdata <= wdata;
         end else begin
            rdata <= mem[ridx];
         end
      end
   end else begin : g_rfirst
      always_ff @(posedge clk) begin
         rdata <= mem[ridx];
      end
   end
endmodule

// File: rtl/palette_stage_writer.sv
module palette_stage_writer
   import pal_pkg::*;
#(
   parameter int unsigned COMP_W      = 6,
   parameter int unsigned IDX_W       = 8,
   parameter logic [7:0]  OFS_BASE    = 8'h08,
   parameter bit          WRITE_FIRST = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_wr,
   input  logic [7:0]                    reg_addr,
   input  logic [7:0]                    reg_wdata,
   output logic [7:0]                    reg_rdata,
   input  logic [IDX_W-1:0]              pix_idx,
   output logic [NUM_SLOTS*COMP_W-1:0]   pix_color
);
   localparam int unsigned ENTRY_W = NUM_SLOTS * COMP_W;

   logic [ENTRY_W-1:0] held;
   logic               commit;
   logic [IDX_W-1:0]   commit_idx;

   pal_stage_regs #(
      .DATA_W   (8),
      .COMP_W   (COMP_W),
      .IDX_W    (IDX_W),
      .OFS_BASE (OFS_BASE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .held       (held),
      .commit     (commit),
      .commit_idx (commit_idx),
      .rdata      (reg_rdata)
   );

   pal_lut_ram #(
      .IDX_W       (IDX_W),
      .ENTRY_W     (ENTRY_W),
      .WRITE_FIRST (WRITE_FIRST)
   ) u_ram (
      .clk   (clk),
      .we    (commit),
      .widx  (commit_idx),
      .wdata (held),
      .ridx  (pix_idx),
      .rdata (pix_color)
   );
endmodule

// File: rtl/pal_writer_chk.sv
module pal_writer_chk #(
   parameter int unsigned COMP_W      = 6,
   parameter int unsigned IDX_W       = 8,
   parameter logic [7:0]  OFS_BASE    = 8'h08,
   parameter bit          WRITE_FIRST = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_wr,
   input logic [7:0]            reg_addr,
   input logic [7:0]            reg_wdata,
   input logic [7:0]            reg_rdata,
   input logic [IDX_W-1:0]      pix_idx,
   input logic [3*COMP_W-1:0]   pix_color,
   input logic [3*COMP_W-1:0]   held
);
   localparam int unsigned LSB = 8 - COMP_W;

   p_blue_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_BASE) |=>
         held[COMP_W-1:0] == $past(reg_wdata[7:LSB]));

   p_green_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_BASE + 8'd1) |=>
         held[2*COMP_W-1:COMP_W] == $past(reg_wdata[7:LSB]));

   p_red_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_BASE + 8'd2) |=>
         held[3*COMP_W-1:2*COMP_W] == $past(reg_wdata[7:LSB]));

   // Covers R6 and R11: nothing but a holding write may alter held values
   p_hold_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr >= OFS_BASE && reg_addr < OFS_BASE + 8'd3) |=>
         $stable(held));

   p_rdata_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> reg_rdata == 8'd0);

   if (WRITE_FIRST) begin : g_collide
      p_commit_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_addr == OFS_BASE + 8'd3 && pix_idx == reg_wdata[IDX_W-1:0]) |=>
            pix_color == $past(held));
   end
endmodule

bind palette_stage_writer pal_writer_chk #(
   .COMP_W      (COMP_W),
   .IDX_W       (IDX_W),
   .OFS_BASE    (OFS_BASE),
   .WRITE_FIRST (WRITE_FIRST)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .pix_idx   (pix_idx),
   .pix_color (pix_color),
   .held      (held)
);

// File: tb/palette_stage_writer_tb.sv
module palette_stage_writer_tb;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [7:0]  pix_idx = '0;
   logic [17:0] pix_color;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;

   logic [5:0]  mb, mg, mr;
   logic [17:0] exp_tab [256];
   bit          vld [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   palette_stage_writer u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pix_idx(pix_idx), .pix_color(pix_color)
   );

   function automatic logic [17:0] pack_rgb(logic [5:0] r, logic [5:0] g, logic [5:0] b);
      return {r, g, b};
   endfunction

   task automatic check(bit ok, string req, logic [17:0] act, logic [17:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %05h expected %05h", req, act, exp);
      end
   endtask

   // One bus cycle (wr may be 0) with a pixel read; checks colour one clock later
   task automatic op(bit wr, logic [7:0] a, logic [7:0] d, logic [7:0] px, string req);
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_wdata = d; pix_idx = px;
      if (wr) begin
         case (a)
            8'h08: mb = d[7:2];
            8'h09: mg = d[7:2];
            8'h0A: mr = d[7:2];
            8'h0B: begin exp_tab[d] = pack_rgb(mr, mg, mb); vld[d] = 1'b1; end
            default: ;
         endcase
      end
      @(negedge clk);
      reg_wr = 1'b0;
      if (vld[px]) check(pix_color === exp_tab[px], req, pix_color, exp_tab[px]);
      check(reg_rdata === 8'd0, "R10", {10'd0, reg_rdata}, 18'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd5150));
      mb = '0; mg = '0; mr = '0;
      for (int i = 0; i < 256; i++) begin vld[i] = 1'b0; exp_tab[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: commit straight after reset gives zero colour; R8 same-cycle read
      op(1'b1, 8'h0B, 8'h05, 8'h05, "R9/R8");
      op(1'b0, 8'h00, 8'h00, 8'h05, "R9");
      // R1..R4: component writes leave entry 5 unchanged
      op(1'b1, 8'h08, 8'hFF, 8'h05, "R1/R4");
      op(1'b1, 8'h09, 8'h56, 8'h05, "R2/R4");
      op(1'b1, 8'h0A, 8'hA9, 8'h05, "R3/R4");
      // R5: commit to 0x10, then read it
      op(1'b1, 8'h0B, 8'h10, 8'h05, "R5");
      op(1'b0, 8'h00, 8'h00, 8'h10, "R5");
      check(pix_color === 18'h2A57F, "R5", pix_color, 18'h2A57F);
      // R6: same colour to another entry without new component writes
      op(1'b1, 8'h0B, 8'h11, 8'h10, "R6");
      op(1'b0, 8'h00, 8'h00, 8'h11, "R6");
      check(pix_color === 18'h2A57F, "R6", pix_color, 18'h2A57F);
      // R11: writes to unused offsets change nothing
      op(1'b1, 8'h0C, 8'h00, 8'h10, "R11");
      op(1'b1, 8'h07, 8'h00, 8'h11, "R11");
      op(1'b1, 8'hFF, 8'h00, 8'h10, "R11");
      op(1'b1, 8'h0B, 8'h12, 8'h12, "R11/R8");
      check(pix_color === 18'h2A57F, "R11", pix_color, 18'h2A57F);
      // R7: alternate indices, each visible one clock after sampling
      for (int k = 0; k < 4; k++) begin
         op(1'b0, 8'h00, 8'h00, (k % 2) ? 8'h05 : 8'h10, "R7");
      end

      // Random mix
      for (int n = 0; n < 3000; n++) begin
         int unsigned sel = $urandom % 10;
         logic [7:0] d  = 8'($urandom);
         logic [7:0] px = 8'($urandom);
         logic [7:0] a;
         case (sel)
            0, 1:    a = 8'h08;
            2:       a = 8'h09;
            3:       a = 8'h0A;
            4, 5, 6: a = 8'h0B;
            7:       a = ($urandom % 2) ? 8'h0C + 8'($urandom % 200) : 8'($urandom % 8);
            default: a = 8'h00;
         endcase
         if (a == 8'h0B && ($urandom % 2)) px = d;
         op(sel < 8, a, d, px, (a == 8'h0B) ? "R5/R8" : "R7/R4");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule